// File: doc/BRIEF.md
# Hub Status Change Reporter

This block holds the change flags of a small hub: one flag for the hub itself and one for each of four downstream ports. Change events arrive as single-cycle pulses, one bit for each source. A flag stays set until the host clears that one flag with an explicit request. The host polls the interrupt status-change endpoint with IN tokens. The block answers each poll with either a NAK or a one-byte bitmap of the flags.

Nothing is reported until the device has been configured. Events that arrive before configuration are still recorded, and they show up on the first poll after configuration. If the configured flag is withdrawn, or a bus reset occurs, every flag is cleared. The packet engine, CRC, data toggle, control endpoint and port hardware all sit outside the block. They reach it only as strobes and flags.

Top module: `hub_chg_report`

## Requirements
- R1: After reset, all five change flags are 0, and neither response output is asserted.
- R2: A pulse on bit i of `chg_evt_i` (bit 0 = hub, bits 1..4 = ports 1..4) sets flag i from the next cycle on. The flag stays set through any number of polls until it is cleared.
- R3: A clear strobe with index 0..4 clears only the flag with that index. A clear index of 5..7 changes no flag.
- R4: When a change pulse and a clear for the same bit fall in the same cycle, the flag is set afterwards.
- R5: A poll strobe produces exactly one response one cycle later, as a single-cycle strobe: either `nak_o` or `dvalid_o`, never both. No response appears without a poll.
- R6: While configured and with at least one flag set, the response is `dvalid_o`. `data_o` then holds flags 4..0 in bits 4..0, with bits 7..5 at 0.
- R7: While configured and with every flag at 0, a poll is answered with `nak_o`.
- R8: While not configured, every poll is answered with `nak_o`. Events seen while not configured are still latched and are reported once configured is 1.
- R9: A falling edge of `configured_i`, or a `bus_reset_i` pulse, clears all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_evt_i | input | 5 | Change pulses, bit 0 hub, bits 1..4 ports |
| clr_stb_i | input | 1 | Host clear request strobe |
| clr_idx_i | input | 3 | Index of the flag to clear |
| configured_i | input | 1 | Device configured level |
| bus_reset_i | input | 1 | Bus reset pulse, clears all flags |
| poll_stb_i | input | 1 | IN token addressed to the status endpoint |
| nak_o | output | 1 | NAK response strobe |
| dvalid_o | output | 1 | Data response strobe |
| data_o | output | 8 | Bitmap byte, valid with dvalid_o |

## Verification
The two functions that can collide are setting a flag from a change pulse and clearing it by host request. The bench drives a pulse and a clear strobe on the same bit index in a single cycle, then polls. The returned byte must still show that bit set. A second collision drives a poll and a new event in the same cycle. The response must reflect the flags as they stood before that edge, and the new event must appear on the following poll.

// File: rtl/hub_chg_pkg.sv
// Package: shared sizes for the hub status change reporter.
// Assumes a hub with one own flag plus a small number of ports.
package hub_chg_pkg;
    parameter int unsigned NPORT  = 4;
    parameter int unsigned NFLAG  = NPORT + 1;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned IDX_W  = 3;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_NAK  = 2'b01,
        RESP_DATA = 2'b10
    } resp_e;
endpackage

// File: rtl/hub_chg_flags.sv
// Module: sticky change flag store.
// Each flag is set by a pulse and cleared by an indexed host clear.
// A set request wins over a clear in the same cycle.
// A flush empties every flag at once.
// Assumes the clear index is sampled only when the clear strobe is high.
module hub_chg_flags #(
    parameter int unsigned NFLAG = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_stb_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    input  logic             flush_i,
    output logic [NFLAG-1:0] flags_o
);
    logic [NFLAG-1:0] flags_q;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic clr_hit;
        // decode the clear request for this flag
        assign clr_hit = clr_stb_i && (clr_idx_i == IDX_W'(g));
        // hold one sticky flag; set wins over clear, flush empties it
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i)
                flags_q[g] <= 1'b0;
            else if (set_i[g])
                flags_q[g] <= 1'b1;
            else if (clr_hit)
                flags_q[g] <= 1'b0;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/hub_chg_resp.sv
// Module: poll responder.
// Registers one response, one cycle after a poll strobe.
// The response is a NAK, or a data byte holding the flag bitmap.
// Assumes flags_i is the registered flag state before this edge.
module hub_chg_resp
    import hub_chg_pkg::*;
#(
    parameter int unsigned NFLAG  = 5,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic              cfg_i,
    input  logic [NFLAG-1:0]  flags_i,
    output logic              nak_o,
    output logic              dvalid_o,
    output logic [BYTE_W-1:0] data_o
);
    localparam int unsigned PAD_W = BYTE_W - NFLAG;

    resp_e             kind_d, kind_q;
    logic [BYTE_W-1:0] byte_q;

    // choose the kind of response for a poll in this cycle
    always_comb begin
        kind_d = RESP_NONE;
        if (poll_i)
            kind_d = (cfg_i && (|flags_i)) ? RESP_DATA : RESP_NAK;
    end

    // register the response kind and the byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RESP_NONE;
            byte_q <= '0;
        end else begin
            kind_q <= kind_d;
            if (kind_d == RESP_DATA)
                byte_q <= {{PAD_W{1'b0}}, flags_i};
        end
    end

    assign nak_o    = (kind_q == RESP_NAK);
    assign dvalid_o = (kind_q == RESP_DATA);
    assign data_o   = dvalid_o ? byte_q : '0;
endmodule

// File: rtl/hub_chg_report.sv
// Module: hub status change reporter, top level.
// Latches hub and port change events.
// Clears all flags on a bus reset or when configuration is lost.
// Answers status endpoint polls.
// Assumes all inputs are synchronous to clk.
module hub_chg_report
    import hub_chg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  chg_evt_i,
    input  logic              clr_stb_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    input  logic              configured_i,
    input  logic              bus_reset_i,
    input  logic              poll_stb_i,
    output logic              nak_o,
    output logic              dvalid_o,
    output logic [BYTE_W-1:0] data_o
);
    logic             cfg_q;
    logic             flush;
    logic [NFLAG-1:0] flags;

    // remember the configured level to detect its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= 1'b0;
        else
            cfg_q <= configured_i;
    end

    assign flush = bus_reset_i || (cfg_q && !configured_i);

    hub_chg_flags #(.NFLAG(NFLAG), .IDX_W(IDX_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (chg_evt_i),
        .clr_stb_i (clr_stb_i),
        .clr_idx_i (clr_idx_i),
        .flush_i   (flush),
        .flags_o   (flags)
    );

    hub_chg_resp #(.NFLAG(NFLAG), .BYTE_W(BYTE_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .poll_i   (poll_stb_i),
        .cfg_i    (configured_i),
        .flags_i  (flags),
        .nak_o    (nak_o),
        .dvalid_o (dvalid_o),
        .data_o   (data_o)
    );
endmodule

// File: rtl/hub_chg_report_chk.sv
// Checker: protocol properties of the hub status change reporter.
// Attached to every instance of the top module with bind.
module hub_chg_report_chk
    import hub_chg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              configured_i,
    input logic              poll_stb_i,
    input logic              nak_o,
    input logic              dvalid_o,
    input logic [BYTE_W-1:0] data_o
);
    // R5
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nak_o && dvalid_o));
    // R5
    resp_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_stb_i |=> (nak_o || dvalid_o));
    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_stb_i |=> !(nak_o || dvalid_o));
    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |-> (data_o[BYTE_W-1:NFLAG] == '0 && data_o[NFLAG-1:0] != '0));
    // R8
    unconfig_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_stb_i && !configured_i) |=> nak_o);
endmodule

bind hub_chg_report hub_chg_report_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .configured_i (configured_i),
    .poll_stb_i   (poll_stb_i),
    .nak_o        (nak_o),
    .dvalid_o     (dvalid_o),
    .data_o       (data_o)
);

// File: tb/hub_chg_report_test.sv
// Directed bench for the hub status change reporter.
// Each scenario is a task that checks its own results.
module hub_chg_report_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] chg_evt_i = '0;
    logic       clr_stb_i = 1'b0;
    logic [2:0] clr_idx_i = '0;
    logic       configured_i = 1'b0;
    logic       bus_reset_i = 1'b0;
    logic       poll_stb_i = 1'b0;
    logic       nak_o, dvalid_o;
    logic [7:0] data_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hub_chg_report uut (
        .clk(clk), .rst_n(rst_n), .chg_evt_i(chg_evt_i),
        .clr_stb_i(clr_stb_i), .clr_idx_i(clr_idx_i),
        .configured_i(configured_i), .bus_reset_i(bus_reset_i),
        .poll_stb_i(poll_stb_i), .nak_o(nak_o), .dvalid_o(dvalid_o),
        .data_o(data_o)
    );

    // drive inputs on the falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // poll once and compare {nak,dvalid,data}
    task automatic poll(string req, logic [9:0] exp);
        poll_stb_i = 1'b1;
        step();
        poll_stb_i = 1'b0;
        check(req, {nak_o, dvalid_o, data_o}, exp);
        step();
    endtask

    task automatic pulse(logic [4:0] ev);
        chg_evt_i = ev;
        step();
        chg_evt_i = '0;
    endtask

    task automatic clear(logic [2:0] idx);
        clr_stb_i = 1'b1;
        clr_idx_i = idx;
        step();
        clr_stb_i = 1'b0;
    endtask

    localparam logic [9:0] NAK = 10'h200;
    function automatic logic [9:0] dat(logic [7:0] b);
        return {2'b01, b};
    endfunction

    task automatic t_reset();
        check("R1 outputs idle", {nak_o, dvalid_o, data_o}, 10'h000);
        configured_i = 1'b1;
        step();
        poll("R1 flags zero after reset", NAK);
    endtask

    task automatic t_sticky();
        pulse(5'b00100);
        poll("R2 port2 reported", dat(8'h04));
        poll("R2 still reported", dat(8'h04));
        pulse(5'b00001);
        poll("R6 hub plus port2", dat(8'h05));
        step();
        check("R5 no response without poll", {nak_o, dvalid_o, data_o}, 10'h000);
    endtask

    task automatic t_clear();
        clear(3'd2);
        poll("R3 only port2 cleared", dat(8'h01));
        pulse(5'b10000);
        clear(3'd5);
        clear(3'd7);
        poll("R3 out of range ignored", dat(8'h11));
        clear(3'd0);
        clear(3'd4);
        poll("R7 empty gives NAK", NAK);
    endtask

    task automatic t_collide();
        chg_evt_i = 5'b01000;
        clr_stb_i = 1'b1;
        clr_idx_i = 3'd3;
        step();
        chg_evt_i = '0;
        clr_stb_i = 1'b0;
        poll("R4 set wins over clear", dat(8'h08));
        clear(3'd3);
        // a poll and an event in the same cycle
        poll_stb_i = 1'b1;
        chg_evt_i = 5'b00010;
        step();
        poll_stb_i = 1'b0;
        chg_evt_i = '0;
        check("R5 poll sees prior state", {nak_o, dvalid_o, data_o}, NAK);
        step();
        poll("R2 event after poll", dat(8'h02));
    endtask

    task automatic t_config();
        configured_i = 1'b0;
        step();
        step();
        configured_i = 1'b0;
        pulse(5'b00001);
        poll("R8 unconfigured NAK", NAK);
        configured_i = 1'b1;
        step();
        poll("R8 latched event reported", dat(8'h01));
        configured_i = 1'b0;
        step();
        configured_i = 1'b1;
        step();
        poll("R9 deconfigure flushed", NAK);
        pulse(5'b11110);
        bus_reset_i = 1'b1;
        step();
        bus_reset_i = 1'b0;
        poll("R9 bus reset flushed", NAK);
    endtask

    initial begin
        fork
            begin
                step();
                step();
                rst_n = 1'b1;
                step();
                t_reset();
                t_sticky();
                t_clear();
                t_collide();
                t_config();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule